// File: doc/BRIEF.md
# High-Voltage Self-Supply Start-Up Sequencer

This block is the supply-management state machine of an off-line switching controller that can feed its own VDD rail from the high-voltage drain node. It sees digitised comparator flags: bulk voltage above the start level, and VDD above the turn-on, recharge and shutdown levels. It also sees a flag that marks the off time of the power switch. From these it decides when the high-voltage charge source is enabled, which of its two current levels is selected, and when the PWM stage may switch.

Each threshold flag passes through a two-flop synchroniser and a glitch filter before the state machine uses it. A mode input chooses between self-supply and auxiliary-winding supply. It is captured only while reset is asserted. In self-supply mode the charge source tops up VDD inside a hysteresis window that runs from the recharge level up to the turn-on level. In auxiliary mode it only covers dips below the recharge level.

Top module: `hv_supply_sequencer`

## Requirements
- R1: While reset is asserted and on the first cycle after it, `hv_src_en_o`, `hv_run_cur_o` and `switch_en_o` are all 0.
- R2: From idle, a bulk flag that is high and stable enables the charge source with the start-up current selected (`hv_src_en_o`=1, `hv_run_cur_o`=0, `switch_en_o`=0).
- R3: During start-up, once the turn-on flag and the shutdown flag are both high, `switch_en_o` goes to 1 and the charge source is disabled in the same cycle. `hv_run_cur_o`=1 from then on, which selects the operating current level.
- R4: In self-supply mode, while switching is enabled, a low recharge flag starts charging. Charging continues until the turn-on flag is high again, including the time when VDD sits between the two levels. While charging, `hv_src_en_o` follows the switch-off flag one cycle later, so it is 0 whenever the switch is on.
- R5: In auxiliary mode, charging during switching also starts on a low recharge flag. It stops as soon as the recharge flag is high again, and the source stays off whenever VDD is above the recharge level.
- R6: A low shutdown flag while switching drops `switch_en_o` and `hv_src_en_o`. Switching then resumes only through a new start-up phase that ends with the turn-on flag.
- R7: A flag pulse shorter than `FILT_LEN` clock cycles (4 by default) has no effect on any output.
- R8: The supply mode is taken from `aux_mode_i` only while reset is asserted. Changes after reset have no effect.
- R9: If the bulk flag falls during start-up, before the turn-on flag is seen, the block returns to idle and all outputs go to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| aux_mode_i | input | 1 | 1 = auxiliary-winding supply, 0 = self-supply; sampled during reset |
| bulk_ok_i | input | 1 | Bulk voltage above start level (asynchronous) |
| vdd_on_i | input | 1 | VDD above turn-on level (asynchronous) |
| vdd_chg_i | input | 1 | VDD above recharge level (asynchronous) |
| vdd_ok_i | input | 1 | VDD above shutdown level (asynchronous) |
| sw_off_i | input | 1 | Power switch is in its off time (synchronous) |
| hv_src_en_o | output | 1 | Enable of the high-voltage charge source |
| hv_run_cur_o | output | 1 | 1 = operating current level, 0 = start-up current level |
| switch_en_o | output | 1 | Switching permission for the PWM stage |

## Verification
A wrong state shows at the ports within one cycle after the filtered flags settle, because every output is registered straight from the next state. If the block is stuck in start-up after VDD reaches the turn-on level, the source stays enabled and switching stays off. If it fails to reach the charge state, the source stays low even though the switch-off flag is high. If it skips the shutdown state, switching continues with VDD below the shutdown level. Problems in the filter show as an output that moves after a pulse shorter than the filter length, or as a response that comes too late.

// File: rtl/hv_supply_pkg.sv
// Package: shared state encoding and flag indices for the supply sequencer.
// Assumes: consumers import it; no parameters live here.
package hv_supply_pkg;

    typedef enum logic [2:0] {
        ST_OFF      = 3'd0,
        ST_STARTUP  = 3'd1,
        ST_RUN_IDLE = 3'd2,
        ST_RUN_CHG  = 3'd3,
        ST_UVLO     = 3'd4
    } sup_state_t;

    localparam int unsigned NUM_FLAGS = 4;
    localparam int unsigned FL_BULK   = 0;
    localparam int unsigned FL_ON     = 1;
    localparam int unsigned FL_CHG    = 2;
    localparam int unsigned FL_OK     = 3;

endpackage

// File: rtl/hv_flag_filter.sv
// Module: two-flop synchroniser followed by a persistence filter for one flag.
// The filtered output takes a new level only after the synchronised input has held
// that level for FILT_LEN consecutive cycles.
// Assumes: FILT_LEN >= 2, input asynchronous to clk.
module hv_flag_filter #(
    parameter int unsigned FILT_LEN  = 4,
    parameter bit          RESET_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic raw_i,
    output logic filt_o
);
    localparam int unsigned CW    = $clog2(FILT_LEN + 1);
    localparam logic [CW-1:0] CMAX = CW'(FILT_LEN - 1);

    logic [1:0]    sync_q;
    logic [CW-1:0] cnt_q;
    logic          filt_q;

    // Purpose: bring the asynchronous flag into the clock domain.
    always_ff @(posedge clk) begin
        if (!rst_n) sync_q <= {2{RESET_VAL}};
        else        sync_q <= {sync_q[0], raw_i};
    end

    // Purpose: count cycles of disagreement and commit a level once it persists.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            filt_q <= RESET_VAL;
        end else if (sync_q[1] == filt_q) begin
            cnt_q  <= '0;
        end else if (cnt_q == CMAX) begin
            cnt_q  <= '0;
            filt_q <= sync_q[1];
        end else begin
            cnt_q  <= cnt_q + 1'b1;
        end
    end

    assign filt_o = filt_q;

    AST_FILT_PERSIST: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(filt_q) |-> ($past(cnt_q) == CMAX)); // R7
    AST_FILT_CNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CMAX); // R7

endmodule

// File: rtl/hv_supply_fsm.sv
// Module: supply sequencing state machine working on filtered threshold flags.
// Registers all three outputs from the next state so that each one is glitch-free.
// Assumes: flags already synchronised and filtered; sw_off_i is synchronous.
module hv_supply_fsm
    import hv_supply_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic aux_mode_i,
    input  logic bulk_f,
    input  logic on_f,
    input  logic chg_f,
    input  logic ok_f,
    input  logic sw_off_i,
    output logic hv_src_en_o,
    output logic hv_run_cur_o,
    output logic switch_en_o
);
    sup_state_t state_q, state_d;
    logic       aux_q;
    logic       hv_en_q, run_cur_q, sw_en_q;
    logic       hv_en_d, run_cur_d, sw_en_d;

    // Purpose: capture the supply mode only while reset is held.
    always_ff @(posedge clk) begin
        if (!rst_n) aux_q <= aux_mode_i;
    end

    // Purpose: next-state decision from the filtered flags.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_OFF: begin
                if (bulk_f) state_d = ST_STARTUP;
            end
            ST_STARTUP: begin
                if (!bulk_f)           state_d = ST_OFF;
                else if (on_f && ok_f) state_d = ST_RUN_IDLE;
            end
            ST_RUN_IDLE: begin
                if (!ok_f)       state_d = ST_UVLO;
                else if (!chg_f) state_d = ST_RUN_CHG;
            end
            ST_RUN_CHG: begin
                if (!ok_f)                    state_d = ST_UVLO;
                else if (aux_q ? chg_f : on_f) state_d = ST_RUN_IDLE;
            end
            ST_UVLO: state_d = ST_OFF;
            default: state_d = ST_OFF;
        endcase
    end

    // Purpose: output values that belong to the next state.
    always_comb begin
        sw_en_d   = (state_d == ST_RUN_IDLE) || (state_d == ST_RUN_CHG);
        run_cur_d = sw_en_d;
        hv_en_d   = (state_d == ST_STARTUP) ||
                    ((state_d == ST_RUN_CHG) && sw_off_i);
    end

    // Purpose: state and output registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q   <= ST_OFF;
            hv_en_q   <= 1'b0;
            run_cur_q <= 1'b0;
            sw_en_q   <= 1'b0;
        end else begin
            state_q   <= state_d;
            hv_en_q   <= hv_en_d;
            run_cur_q <= run_cur_d;
            sw_en_q   <= sw_en_d;
        end
    end

    assign hv_src_en_o  = hv_en_q;
    assign hv_run_cur_o = run_cur_q;
    assign switch_en_o  = sw_en_q;

    AST_SW_NEEDS_ON: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sw_en_q) |-> ($past(on_f) && !hv_en_q)); // R3
    AST_CHG_ONLY_OFFTIME: assert property (@(posedge clk) disable iff (!rst_n)
        (hv_en_q && sw_en_q) |-> $past(sw_off_i)); // R4
    AST_AUX_NO_CHG_ABOVE: assert property (@(posedge clk) disable iff (!rst_n)
        (aux_q && chg_f && sw_en_q) |=> !hv_en_q); // R5
    AST_UVLO_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!ok_f) |-> !sw_en_q); // R6
    AST_MODE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        $stable(aux_q)); // R8
    AST_ABORT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_STARTUP && !bulk_f) |=> (!hv_en_q && !sw_en_q)); // R9

endmodule

// File: rtl/hv_supply_sequencer.sv
// Module: top level of the high-voltage self-supply start-up sequencer.
// Filters each VDD/bulk threshold flag and feeds the sequencing state machine.
// Assumes: single clock, synchronous active-low reset, sw_off_i in the clk domain.
module hv_supply_sequencer
    import hv_supply_pkg::*;
#(
    parameter int unsigned FILT_LEN = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic aux_mode_i,
    input  logic bulk_ok_i,
    input  logic vdd_on_i,
    input  logic vdd_chg_i,
    input  logic vdd_ok_i,
    input  logic sw_off_i,
    output logic hv_src_en_o,
    output logic hv_run_cur_o,
    output logic switch_en_o
);
    logic [NUM_FLAGS-1:0] raw_flags;
    logic [NUM_FLAGS-1:0] filt_flags;

    assign raw_flags[FL_BULK] = bulk_ok_i;
    assign raw_flags[FL_ON]   = vdd_on_i;
    assign raw_flags[FL_CHG]  = vdd_chg_i;
    assign raw_flags[FL_OK]   = vdd_ok_i;

    for (genvar g = 0; g < NUM_FLAGS; g++) begin : g_filt
        hv_flag_filter #(
            .FILT_LEN  (FILT_LEN),
            .RESET_VAL (1'b0)
        ) i_filt (
            .clk    (clk),
            .rst_n  (rst_n),
            .raw_i  (raw_flags[g]),
            .filt_o (filt_flags[g])
        );
    end

    hv_supply_fsm i_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .aux_mode_i   (aux_mode_i),
        .bulk_f       (filt_flags[FL_BULK]),
        .on_f         (filt_flags[FL_ON]),
        .chg_f        (filt_flags[FL_CHG]),
        .ok_f         (filt_flags[FL_OK]),
        .sw_off_i     (sw_off_i),
        .hv_src_en_o  (hv_src_en_o),
        .hv_run_cur_o (hv_run_cur_o),
        .switch_en_o  (switch_en_o)
    );

    AST_RESET_QUIET: assert property (@(posedge clk)
        !rst_n |=> (!hv_src_en_o && !hv_run_cur_o && !switch_en_o)); // R1
    AST_CUR_MATCHES_RUN: assert property (@(posedge clk) disable iff (!rst_n)
        (hv_src_en_o && !switch_en_o) |-> !hv_run_cur_o); // R2

endmodule

// File: tb/test_hv_supply_sequencer.sv
module test_hv_supply_sequencer;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic aux_mode = 1'b0;
    logic bulk = 1'b0, on = 1'b0, chg = 1'b0, ok = 1'b0, swoff = 1'b0;
    logic hv_en, run_cur, sw_en;
    int   n_chk = 0;
    int   n_fail = 0;
    bit   done = 1'b0;

    always #10 clk = ~clk; // 50 MHz

    hv_supply_sequencer i_hv_supply_sequencer (
        .clk(clk), .rst_n(rst_n), .aux_mode_i(aux_mode),
        .bulk_ok_i(bulk), .vdd_on_i(on), .vdd_chg_i(chg), .vdd_ok_i(ok),
        .sw_off_i(swoff), .hv_src_en_o(hv_en), .hv_run_cur_o(run_cur),
        .switch_en_o(sw_en)
    );

    // inputs [7:3] = bulk,on,chg,ok,swoff ; expected [2:0] = hv_en,run_cur,sw_en
    localparam logic [7:0] VEC [0:10] = '{
        8'b00000_000, // R2 idle
        8'b10000_100, // R2 start-up charge
        8'b10110_100, // R2 VDD rising
        8'b11110_011, // R3 switching, source off
        8'b10111_011, // R4 between levels, no charge
        8'b10011_111, // R4 below recharge, switch off
        8'b10010_011, // R4 gated while switch on
        8'b10111_111, // R4 hysteresis keeps charging
        8'b11111_011, // R4 back at turn-on level
        8'b10001_100, // R6 shutdown then fresh start-up
        8'b11110_011  // R6 restart via turn-on
    };
    localparam int VREQ [0:10] = '{2, 2, 2, 3, 4, 4, 4, 4, 4, 6, 6};

    task automatic check(input string req, input logic [2:0] exp);
        n_chk++;
        if ({hv_en, run_cur, sw_en} !== exp) begin
            n_fail++;
            $display("FAIL %s: got %b expected %b", req, {hv_en, run_cur, sw_en}, exp);
        end
    endtask

    task automatic drive(input logic [4:0] v);
        @(negedge clk);
        {bulk, on, chg, ok, swoff} = v;
    endtask

    task automatic settle();
        repeat (12) @(negedge clk);
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            finish_run();
        end
    end

    initial begin
        // R1: reset state
        repeat (3) @(negedge clk);
        check("R1", 3'b000);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", 3'b000);

        // Table walk in self-supply mode
        for (int i = 0; i < 11; i++) begin
            drive(VEC[i][7:3]);
            settle();
            check($sformatf("R%0d", VREQ[i]), VEC[i][2:0]);
        end

        // R7: short pulse on shutdown flag while running
        drive(5'b11111);
        settle();
        drive(5'b11101);
        drive(5'b11111);
        for (int k = 0; k < 12; k++) begin
            @(negedge clk);
            check("R7", 3'b011);
        end

        // R9: bulk lost during start-up
        rst_n = 1'b0;
        drive(5'b00000);
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        drive(5'b10000);
        settle();
        check("R9", 3'b100);
        drive(5'b00110);
        settle();
        check("R9", 3'b000);

        // R5 and R8: auxiliary mode captured in reset, input changed afterwards
        aux_mode = 1'b1;
        rst_n = 1'b0;
        drive(5'b00000);
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        aux_mode = 1'b0; // R8: must be ignored
        drive(5'b10000);
        settle();
        check("R5", 3'b100);
        drive(5'b11110);
        settle();
        check("R5", 3'b011);
        drive(5'b10011);
        settle();
        check("R5", 3'b111);
        drive(5'b10111);
        settle();
        check("R8", 3'b011); // self mode would still charge here

        done = 1'b1;
        finish_run();
    end
endmodule